// File: doc/BRIEF.md
# Command-Word I2C Master

This block is an I2C bus master driven by a host through four 16-bit registers. Each bus transaction is launched by one write of a command word. The command word names a 7-bit target, a direction and a transfer size of zero, one or two bytes. It also carries a flag that keeps the bus claimed after the transfer, so that the next command opens with a repeated START instead of a fresh one. Outgoing bytes are staged beforehand in a write-data register. Incoming bytes land in a read-data register.

The controller generates START, the address byte, the data bytes and the acknowledge slots, and it ends with STOP unless the bus is to be kept. Three sticky events report the outcome: transmit done, receive done and error. Software clears them by writing ones. A zero-length command sends only the address, which lets the host find out whether a target answers. SCL comes from a fixed divider. Both lines are open-drain style: an output either pulls the line low or releases it.

Top module: `cmd_i2c_master`

## Requirements
- R1: Register index 0 takes the command word: target address in bits 7:1, bit 10 set for a write and clear for a read, bit 11 set for two data bytes, bit 12 set for an address-only transfer, bit 13 set to keep the bus, bits 15:14 equal to 2 for a valid command. A valid write to index 0 starts a transaction whose first byte is the address followed by the direction bit (1 = read). Reading index 0 returns zero.
- R2: Index 2 holds the outgoing data and reads back as written. Index 3 is read-only and holds received data. In both, the first bus byte sits in bits 7:0 and the second in bits 15:8.
- R3: Index 1 reads as the status word: bit 13 error, bit 14 transmit done, bit 15 receive done, all other bits zero. Each event stays set until a write to index 1 with a 1 in that bit position clears it. Writing a 0 leaves the event unchanged.
- R4: A write command sends the low byte of index 2 and then, for two-byte commands, the high byte. Each byte must be acknowledged. If all are acknowledged, transmit done is raised.
- R5: A read command fills index 3 with one or two received bytes, with the high byte zero for a one-byte read. The master acknowledges every byte except the last, which it does not acknowledge. Receive done is raised.
- R6: An address-only command sends just the address byte. If the target acknowledges, the event for the command's direction is raised (transmit done for a write, receive done for a read). If it does not, error is raised.
- R7: A missing acknowledge on the address or on any written byte raises error only. The master then issues STOP even when the keep-bus flag is set.
- R8: With keep-bus set and no error, no STOP is sent and SCL stays low after the event is raised. The next command then starts with a repeated START.
- R9: A command word whose bits 15:14 are not 2 raises error and causes no bus activity.
- R10: A command written while a transaction is running is ignored and raises error. The running transaction finishes unchanged.
- R11: Each bit occupies 4 x CLK_DIV clock cycles, so rising SCL edges within a transaction are never closer than that. SDA changes only while SCL is low, except for START and STOP. An idle bus has both lines released.
- R12: After reset, both lines are released and the status word and index 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed level of SDA |

## Verification
The bench builds the block with CLK_DIV = 2, so one bit lasts eight clocks and a full two-byte transaction fits in a few hundred cycles. This brings a near-exhaustive sweep within reach: both directions, all three sizes, keep-bus on and off, and three target behaviours (acknowledge, wrong address, refused last write byte). Each case runs against a behavioural target on the bus. The sweep also chains kept-bus cases into repeated STARTs. Separate cases cover invalid modes, a command during a running transfer and partial event clearing.

// File: rtl/cmd_i2c_pkg.sv
package cmd_i2c_pkg;

    localparam int REG_W = 16;

    localparam logic [1:0] IDX_CMD  = 2'd0;
    localparam logic [1:0] IDX_STAT = 2'd1;
    localparam logic [1:0] IDX_TXD  = 2'd2;
    localparam logic [1:0] IDX_RXD  = 2'd3;

    localparam int CB_WRITE = 10;
    localparam int CB_PAIR  = 11;
    localparam int CB_ADONLY = 12;
    localparam int CB_KEEP  = 13;
    localparam int CB_MODE_LO = 14;
    localparam logic [1:0] MODE_OK = 2'b10;

    // event vector order {rx_done, tx_done, error} = status bits 15:13
    localparam int EV_LSB = 13;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_BIT,
        PH_STOP,
        PH_KEEP
    } bus_state_e;

    typedef struct packed {
        logic [6:0] target;
        logic       is_read;
        logic       pair;
        logic       adonly;
        logic       keep;
    } xfer_t;

endpackage

// File: rtl/cmd_i2c_tick.sv
module cmd_i2c_tick #(
    parameter int CLK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cmd_i2c_engine.sv
module cmd_i2c_engine
    import cmd_i2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        start_i,
    input  xfer_t       xfer_i,
    input  logic [15:0] txd_i,
    input  logic        sda_in,
    output logic        busy_o,
    output logic        scl_low_o,
    output logic        sda_low_o,
    output logic        done_err_o,
    output logic        done_tx_o,
    output logic        done_rx_o,
    output logic [15:0] rxd_o
);
    typedef struct packed {
        bus_state_e  st;
        logic [1:0]  ph;
        logic [3:0]  bitc;
        logic [1:0]  byten;
        logic [7:0]  sh;
        logic [15:0] rxw;
        logic        nack;
        logic        scl_low;
        logic        sda_low;
        logic        done;
        xfer_t       xf;
        logic [15:0] txw;
    } eng_t;

    eng_t q, n;
    logic       tx_byte;
    logic       last_byte;
    logic [1:0] nbytes;

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        nbytes    = q.xf.adonly ? 2'd0 : (q.xf.pair ? 2'd2 : 2'd1);
        tx_byte   = (q.byten == 2'd0) || !q.xf.is_read;
        last_byte = (q.byten == nbytes);
        if (start_i) begin
            n.xf   = xfer_i;
            n.txw  = txd_i;
            n.st   = PH_START;
            n.ph   = 2'd0;
            n.nack = 1'b0;
            n.rxw  = '0;
        end else if (tick) begin
            n.ph = q.ph + 2'd1;
            case (q.st)
                PH_START: begin
                    case (q.ph)
                        2'd0: n.sda_low = 1'b0;
                        2'd1: n.scl_low = 1'b0;
                        2'd2: n.sda_low = 1'b1;
                        default: begin
                            n.scl_low = 1'b1;
                            n.st      = PH_BIT;
                            n.bitc    = '0;
                            n.byten   = '0;
                            n.sh      = {q.xf.target, q.xf.is_read};
                        end
                    endcase
                end
                PH_BIT: begin
                    case (q.ph)
                        2'd0: begin
                            if (q.bitc < 4'd8) n.sda_low = tx_byte ? !q.sh[7] : 1'b0;
                            else               n.sda_low = tx_byte ? 1'b0 : !last_byte;
                        end
                        2'd1: n.scl_low = 1'b0;
                        2'd2: begin
                            if (q.bitc < 4'd8) begin
                                if (!tx_byte) n.sh = {q.sh[6:0], sda_in};
                            end else if (tx_byte) begin
                                n.nack = sda_in;
                            end
                        end
                        default: begin
                            n.scl_low = 1'b1;
                            if (q.bitc < 4'd8) begin
                                n.bitc = q.bitc + 4'd1;
                                if (tx_byte) n.sh = {q.sh[6:0], 1'b0};
                            end else if (tx_byte && q.nack) begin
                                n.st = PH_STOP;
                            end else begin
                                if (!tx_byte) begin
                                    if (q.byten == 2'd1) n.rxw[7:0]  = q.sh;
                                    else                 n.rxw[15:8] = q.sh;
                                end
                                if (last_byte) begin
                                    if (q.xf.keep) begin
                                        n.st      = PH_KEEP;
                                        n.sda_low = 1'b0;
                                        n.done    = 1'b1;
                                    end else begin
                                        n.st = PH_STOP;
                                    end
                                end else begin
                                    n.byten = q.byten + 2'd1;
                                    n.bitc  = '0;
                                    n.sh    = q.xf.is_read ? 8'h00 :
                                              ((q.byten == 2'd0) ? q.txw[7:0] : q.txw[15:8]);
                                end
                            end
                        end
                    endcase
                end
                PH_STOP: begin
                    case (q.ph)
                        2'd0: n.sda_low = 1'b1;
                        2'd1: n.scl_low = 1'b0;
                        2'd2: n.sda_low = 1'b0;
                        default: begin
                            n.st   = PH_IDLE;
                            n.done = 1'b1;
                        end
                    endcase
                end
                default: n.ph = 2'd0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy_o     = (q.st != PH_IDLE) && (q.st != PH_KEEP);
    assign scl_low_o  = q.scl_low;
    assign sda_low_o  = q.sda_low;
    assign done_err_o = q.done && q.nack;
    assign done_tx_o  = q.done && !q.nack && !q.xf.is_read;
    assign done_rx_o  = q.done && !q.nack && q.xf.is_read;
    assign rxd_o      = q.rxw;

    AST_START_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);  // R10
    AST_NACK_ENDS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done_err_o |-> (q.st == PH_IDLE) && !scl_low_o && !sda_low_o);  // R7
    AST_SDA_MOVES_UNDER_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == PH_BIT) && ($past(q.st) == PH_BIT) && !$stable(sda_low_o))
        |-> (scl_low_o && $past(scl_low_o)));  // R11
    AST_KEEP_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PH_KEEP) |-> scl_low_o);  // R8

endmodule

// File: rtl/cmd_i2c_regs.sv
module cmd_i2c_regs
    import cmd_i2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        busy_i,
    input  logic        done_err_i,
    input  logic        done_tx_i,
    input  logic        done_rx_i,
    input  logic [15:0] rxd_i,
    output logic        start_o,
    output xfer_t       xfer_o,
    output logic [15:0] txd_o
);
    typedef struct packed {
        logic [2:0]  ev;
        logic [15:0] txd;
        logic [15:0] rxd;
    } regs_t;

    regs_t q, n;
    logic       cmd_wr;
    logic       mode_ok;
    logic [2:0] clr;
    logic [2:0] ev_q;

    always_comb begin
        n       = q;
        cmd_wr  = reg_wr && (reg_addr == IDX_CMD);
        mode_ok = reg_wdata[CB_MODE_LO+1:CB_MODE_LO] == MODE_OK;
        start_o = cmd_wr && mode_ok && !busy_i;
        clr     = (reg_wr && (reg_addr == IDX_STAT)) ? reg_wdata[EV_LSB+2:EV_LSB] : 3'b000;
        n.ev    = q.ev & ~clr;
        if ((cmd_wr && (!mode_ok || busy_i)) || done_err_i) n.ev[0] = 1'b1;
        if (done_tx_i) n.ev[1] = 1'b1;
        if (done_rx_i) n.ev[2] = 1'b1;
        if (reg_wr && (reg_addr == IDX_TXD)) n.txd = reg_wdata;
        if (done_rx_i) n.rxd = rxd_i;
    end

    always_comb begin
        xfer_o.target  = reg_wdata[7:1];
        xfer_o.is_read = !reg_wdata[CB_WRITE];
        xfer_o.pair    = reg_wdata[CB_PAIR];
        xfer_o.adonly  = reg_wdata[CB_ADONLY];
        xfer_o.keep    = reg_wdata[CB_KEEP];
    end

    always_comb begin
        case (reg_addr)
            IDX_STAT: reg_rdata = {q.ev, 13'd0};
            IDX_TXD:  reg_rdata = q.txd;
            IDX_RXD:  reg_rdata = q.rxd;
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign txd_o = q.txd;
    assign ev_q  = q.ev;

    AST_EVENTS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_q) |=> ((ev_q & ($past(ev_q) & ~$past(clr))) == ($past(ev_q) & ~$past(clr))));  // R3
    AST_BAD_MODE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == IDX_CMD) && (reg_wdata[15:14] != MODE_OK)) |=> ev_q[0]);  // R9
    AST_BUSY_CMD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == IDX_CMD) && busy_i) |=> ev_q[0]);  // R10

endmodule

// File: rtl/cmd_i2c_master.sv
module cmd_i2c_master
    import cmd_i2c_pkg::*;
#(
    parameter int CLK_DIV = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        scl_pull,
    output logic        sda_pull,
    input  logic        sda_in
);
    logic        tick, busy, start;
    logic        d_err, d_tx, d_rx;
    logic [15:0] rxd, txd;
    xfer_t       xfer;

    cmd_i2c_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    cmd_i2c_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy_i(busy), .done_err_i(d_err), .done_tx_i(d_tx), .done_rx_i(d_rx), .rxd_i(rxd),
        .start_o(start), .xfer_o(xfer), .txd_o(txd)
    );

    cmd_i2c_engine u_engine (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_i(start), .xfer_i(xfer), .txd_i(txd), .sda_in(sda_in),
        .busy_o(busy), .scl_low_o(scl_pull), .sda_low_o(sda_pull),
        .done_err_o(d_err), .done_tx_o(d_tx), .done_rx_o(d_rx), .rxd_o(rxd)
    );

endmodule

// File: tb/cmd_i2c_master_tb.sv
module cmd_i2c_master_tb;
    localparam int DIV = 2;
    localparam logic [6:0] TGT = 7'h52;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        scl_pull, sda_pull;
    logic        s_oe = 1'b0;
    logic        scl_line, sda_line;

    assign scl_line = !scl_pull;
    assign sda_line = !(sda_pull || s_oe);

    cmd_i2c_master #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_line)
    );

    always #10ns clk = !clk;

    int n_cmp = 0, n_bad = 0;

    // behavioural target on the bus
    logic [7:0] rd_b0 = 8'h80, rd_b1 = 8'h00;
    int nack_wr_at = 0;
    int mode = 3, bitn = 0, dbyte = 0, pend_mode = 0;
    logic pend = 1'b0, active = 1'b0;
    logic [7:0] sh = 8'h00;
    logic [7:0] wlog [0:3];
    int wcnt = 0, macks = 0, mnacks = 0, starts = 0, stops = 0, rstarts = 0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    logic [7:0] cur;

    always @(scl_line, sda_line) begin
        if (scl_line && prev_scl && prev_sda && !sda_line) begin
            if (active) rstarts++;
            starts++; active = 1'b1; mode = 0; bitn = 0; pend = 1'b0; dbyte = 0;
            wcnt = 0; macks = 0; mnacks = 0; s_oe = 1'b0;
        end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
            stops++; active = 1'b0; mode = 3; s_oe = 1'b0;
        end else if (scl_line && !prev_scl) begin
            if (bitn < 8) begin
                if (mode != 2) sh = {sh[6:0], sda_line};
                bitn++;
            end else begin
                if (mode == 2) begin
                    if (sda_line) begin mnacks++; mode = 3; end
                    else macks++;
                end
                bitn = 0;
            end
        end else if (!scl_line && prev_scl) begin
            cur = (dbyte == 0) ? rd_b0 : rd_b1;
            if (mode == 0 && bitn == 8) begin
                if (sh[7:1] == TGT) begin
                    s_oe = 1'b1; pend = 1'b1; pend_mode = sh[0] ? 2 : 1;
                end else mode = 3;
            end else if (mode == 1 && bitn == 8) begin
                dbyte++;
                if (wcnt < 4) wlog[wcnt] = sh;
                wcnt++;
                s_oe = (nack_wr_at == dbyte) ? 1'b0 : 1'b1;
            end else if (bitn == 0 && pend) begin
                pend = 1'b0; mode = pend_mode; s_oe = 1'b0;
                if (mode == 2) s_oe = !rd_b0[7];
            end else if (mode == 2 && bitn < 8) begin
                s_oe = !cur[7-bitn];
            end else if (mode == 2 && bitn == 8) begin
                s_oe = 1'b0; dbyte++;
            end else if (bitn == 0) begin
                s_oe = 1'b0;
            end
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    // SCL rise spacing monitor
    int cyc = 0, last_rise = -1, min_gap = 1000000;
    logic scl_c = 1'b1;
    always @(posedge clk) begin
        cyc++;
        if (scl_line && !scl_c) begin
            if (last_rise >= 0 && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
            last_rise = cyc;
        end
        scl_c = scl_line;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1ns;
        d = reg_rdata;
    endtask

    task automatic wait_ev(input logic [15:0] mask);
        logic [15:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd1, s);
            if ((s & mask) != 0) return;
        end
        n_cmp++; n_bad++;
        $display("FAIL watchdog: no event, actual 0 expected %h", mask);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v, w, cmdw;
        logic held;
        int k, st0, sp0, rs0;
        logic ok, isw;
        logic [6:0] ta;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd1, v); chk("R12 status after reset", v, 0);
        rd(2'd3, v); chk("R12 rx data after reset", v, 0);
        chk("R12 lines released", {scl_line, sda_line}, 2'b11);
        rd(2'd0, v); chk("R1 command index reads zero", v, 0);

        held = 1'b0; k = 0;
        for (int dir = 0; dir < 2; dir++)
        for (int len = 0; len < 3; len++)
        for (int hold = 0; hold < 2; hold++)
        for (int fault = 0; fault < 3; fault++) begin
            isw = (dir == 0);
            if (fault == 2 && !(isw && len > 0)) continue;
            k++;
            rd_b0 = 8'h80 | 8'(k);
            rd_b1 = 8'h3C ^ 8'(k);
            w = {8'hC3 ^ 8'(k), 8'h5A + 8'(k)};
            nack_wr_at = (fault == 2) ? len : 0;
            ta = (fault == 1) ? 7'h31 : TGT;
            wr(2'd2, w);
            rd(2'd2, v); chk("R2 write data readback", v, w);
            sp0 = stops; rs0 = rstarts;
            cmdw = 16'h8000 | (16'(isw) << 10) | (16'(len == 2) << 11) |
                   (16'(len == 0) << 12) | (16'(hold) << 13) | (16'(ta) << 1);
            wr(2'd0, cmdw);
            wait_ev(16'hE000);
            ok = (fault == 0) || (fault == 2 && !(isw && len > 0));
            rd(2'd1, v);
            chk(len == 0 ? "R6 probe outcome" : (ok ? (isw ? "R4 tx event" : "R5 rx event") : "R7 error event"),
                v, ok ? (isw ? 16'h4000 : 16'h8000) : 16'h2000);
            chk("R8 repeated start after keep", rstarts - rs0, held ? 1 : 0);
            held = ok && (hold == 1);
            chk(ok ? "R8 stop only without keep" : "R7 stop after nack", stops - sp0, held ? 0 : 1);
            if (held) chk("R8 scl held low", scl_line, 0);
            else      chk("R11 bus released", {scl_line, sda_line}, 2'b11);
            if (ok && isw && len > 0) begin
                chk("R4 bytes sent", wcnt, len);
                chk("R4 first byte", wlog[0], w[7:0]);
                if (len == 2) chk("R4 second byte", wlog[1], w[15:8]);
            end
            if (ok && !isw && len > 0) begin
                rd(2'd3, v);
                chk("R5 rx data order", v, (len == 2) ? {rd_b1, rd_b0} : {8'h00, rd_b0});
                chk("R5 master acks", macks, len - 1);
                chk("R5 final nack", mnacks, 1);
            end
            wr(2'd1, 16'hE000);
            rd(2'd1, v); chk("R3 write-one clears", v, 0);
        end
        if (held) begin
            wr(2'd0, 16'h8000 | 16'h1400 | (16'(TGT) << 1));
            wait_ev(16'hE000);
            wr(2'd1, 16'hE000);
            held = 1'b0;
        end
        chk("R11 bus idle", {scl_line, sda_line}, 2'b11);

        // R9 invalid mode values
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            st0 = starts;
            wr(2'd0, (16'(m) << 14) | 16'h0400 | (16'(TGT) << 1));
            repeat (40) @(negedge clk);
            rd(2'd1, v); chk("R9 bad mode error", v, 16'h2000);
            chk("R9 no bus activity", starts - st0, 0);
            wr(2'd1, 16'hE000);
        end

        // R10 command during a running transfer, R3 partial clear
        nack_wr_at = 0;
        wr(2'd2, 16'hB7E1);
        st0 = starts;
        wr(2'd0, 16'h8C00 | (16'(TGT) << 1));
        repeat (10) @(negedge clk);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h8000 | (16'(TGT) << 1));
        rd(2'd1, v); chk("R10 busy command flags error", v, 16'h2000);
        wait_ev(16'h4000);
        rd(2'd1, v); chk("R10 original transfer completes", v, 16'h6000);
        chk("R10 single start", starts - st0, 1);
        chk("R10 first byte intact", wlog[0], 8'hE1);
        chk("R10 second byte intact", wlog[1], 8'hB7);
        wr(2'd1, 16'h8000);
        rd(2'd1, v); chk("R3 clearing unset bit no effect", v, 16'h6000);
        wr(2'd1, 16'h2000);
        rd(2'd1, v); chk("R3 selective clear", v, 16'h4000);
        repeat (50) @(negedge clk);
        rd(2'd1, v); chk("R3 event stays set", v, 16'h4000);

        chk("R11 min SCL rise spacing", min_gap, 4 * DIV);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule